// File: doc/BRIEF.md
# Device search triplet unit

This block carries out a single branch step of the binary identity search on a single-wire bus. After a start strobe it asks a bit-level bus master for two read slots. The first slot returns the identity bit that all responding devices drive at the current position. The second returns the complement of that bit. From the pair it decides which branch of the identity tree to follow. It then asks for one write slot carrying that branch bit, and devices whose identity does not match drop out of the search.

A packed 3-bit result word and a one-cycle done strobe report the outcome. If both reads return 1, no device answered. In that case the unit skips the write slot, flags that the search has to start over, and reports the error code. The loop over all identity positions, the bookkeeping of discrepancy positions and the checksum of the identity sit outside this block.

The slot request can be a level held until the acknowledge arrives, or a single-cycle pulse. The parameter `REQ_STYLE` selects between them.

Top module: `srch_triplet_unit`

## Requirements
- R1: After an accepted start, the first two slot requests are read slots (`slot_wr_o` = 0). The sampled bit of the first is taken as the identity bit and the sampled bit of the second as the complement bit.
- R2: When both sampled bits are 1, the result word is 3'b011 and `restart_o` is 1 in the done cycle. No write slot is requested, and done follows in the cycle after the second read acknowledge.
- R3: When both sampled bits are 0, the chosen direction is the preferred-direction value captured at start.
- R4: When exactly one sampled bit is 1, the chosen direction equals the identity bit.
- R5: Layout of the result word: bit 0 is the identity bit, bit 1 is the complement bit and bit 2 is the chosen direction. Only 3'b000, 3'b100, 3'b010, 3'b101 and 3'b011 can occur. `restart_o` is 0 for every code except 3'b011.
- R6: Whenever no error is found, a third request follows that is a write slot (`slot_wr_o` = 1) with `slot_wbit_o` equal to the chosen direction. Done is raised in the cycle after that slot's acknowledge.
- R7: The preferred direction is captured in the cycle that start is accepted. Later changes of `pref_dir_i` do not affect the step in progress.
- R8: A start that arrives while `busy_o` is 1 is ignored. It does not alter the result and does not cause an extra step. An accepted start makes `busy_o` 1 in the next cycle.
- R9: `done_o` is high for exactly one cycle per step. `status_o` changes only in that cycle and holds its value until the next done.
- R10: The unit does not advance while a slot is outstanding. The request stays pending and done stays low for as long as `slot_ack_i` is withheld.
- R11: During and after reset, `busy_o`, `done_o`, `restart_o` and `slot_req_o` are 0 and `status_o` is 3'b000.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start one search step (accepted only when idle) |
| pref_dir_i | input | 1 | Branch taken when the two reads are both 0 |
| busy_o | output | 1 | A step is in progress |
| done_o | output | 1 | One-cycle strobe, result valid |
| restart_o | output | 1 | With done: no device responded, search must restart |
| status_o | output | 3 | {direction, complement bit, identity bit} |
| slot_req_o | output | 1 | Slot request to the bit-level master |
| slot_wr_o | output | 1 | 1 = write slot, 0 = read slot |
| slot_wbit_o | output | 1 | Bit to send in a write slot |
| slot_ack_i | input | 1 | Slot finished (one cycle) |
| slot_rbit_i | input | 1 | Level sampled in the finished read slot |

## Verification
The bench goes after the no-response case. A design that wrongly issues the direction write there would show up as an extra request, or as a late or missing done. In the discrepancy case, a design that samples `pref_dir_i` live instead of latching it would follow the value the bench changes right after start. Starts pulsed in the middle of a step and acknowledges withheld for many cycles are aimed at a unit that restarts, skips a slot or reports early. Random bit pairs with random acknowledge latency check the position of every field in the result word.

// File: rtl/trip_pkg.sv
package trip_pkg;
   localparam int unsigned STAT_W = 3;
   localparam logic [STAT_W-1:0] STAT_NOBODY = 3'b011;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_ID,
      ST_RD_CMP,
      ST_WR_DIR,
      ST_DONE
   } trip_state_e;

   function automatic logic pick_dir(input logic id_b, input logic cmp_b, input logic pref_b);
      return (id_b ^ cmp_b) ? id_b : pref_b;
   endfunction
endpackage

// File: rtl/trip_decide.sv
module trip_decide
   import trip_pkg::*;
(
   input  logic              id_b,
   input  logic              cmp_b,
   input  logic              pref_b,
   output logic              dir_o,
   output logic [STAT_W-1:0] status_o
);
   always_comb begin
      dir_o    = pick_dir(id_b, cmp_b, pref_b);
      status_o = {dir_o, cmp_b, id_b};
   end
endmodule

// File: rtl/trip_slot_if.sv
module trip_slot_if #(
   parameter int unsigned REQ_STYLE = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slot_act,
   input  logic slot_ack,
   output logic slot_req
);
   if (REQ_STYLE > 1) begin : g_bad_style
      $error("trip_slot_if: REQ_STYLE must be 0 (level) or 1 (pulse)");
   end

   if (REQ_STYLE == 0) begin : g_level
      assign slot_req = slot_act;
   end else begin : g_pulse
      logic sent_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   sent_q <= 1'b0;
         else if (slot_ack || !slot_act) sent_q <= 1'b0;
         else if (slot_req)            sent_q <= 1'b1;
      end
      assign slot_req = slot_act & ~sent_q;
   end
endmodule

// File: rtl/trip_fsm.sv
module trip_fsm
   import trip_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_i,
   input  logic        pref_i,
   input  logic        ack_i,
   input  logic        rbit_i,
   output trip_state_e state_o,
   output logic        id_q,
   output logic        cmp_q,
   output logic        pref_q,
   output logic        to_done_err,
   output logic        to_done_ok
);
   trip_state_e st_q, st_d;
   logic        both_one;

   assign both_one    = id_q & rbit_i;
   assign to_done_err = (st_q == ST_RD_CMP) && ack_i && both_one;
   assign to_done_ok  = (st_q == ST_WR_DIR) && ack_i;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:   if (start_i) st_d = ST_RD_ID;
         ST_RD_ID:  if (ack_i)   st_d = ST_RD_CMP;
         ST_RD_CMP: if (ack_i)   st_d = both_one ? ST_DONE : ST_WR_DIR;
         ST_WR_DIR: if (ack_i)   st_d = ST_DONE;
         ST_DONE:                st_d = ST_IDLE;
         default:                st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         id_q   <= 1'b0;
         cmp_q  <= 1'b0;
         pref_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_IDLE && start_i)  pref_q <= pref_i;
         if (st_q == ST_RD_ID && ack_i)   id_q   <= rbit_i;
         if (st_q == ST_RD_CMP && ack_i)  cmp_q  <= rbit_i;
      end
   end

   assign state_o = st_q;
endmodule

// File: rtl/srch_triplet_unit.sv
module srch_triplet_unit
   import trip_pkg::*;
#(
   parameter int unsigned REQ_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              pref_dir_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              restart_o,
   output logic [STAT_W-1:0] status_o,
   output logic              slot_req_o,
   output logic              slot_wr_o,
   output logic              slot_wbit_o,
   input  logic              slot_ack_i,
   input  logic              slot_rbit_i
);
   trip_state_e       state;
   logic              id_q, cmp_q, pref_q;
   logic              to_done_err, to_done_ok;
   logic              dir_w, slot_act;
   logic [STAT_W-1:0] status_w, status_q;
   logic              err_q;

   trip_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .pref_i      (pref_dir_i),
      .ack_i       (slot_ack_i),
      .rbit_i      (slot_rbit_i),
      .state_o     (state),
      .id_q        (id_q),
      .cmp_q       (cmp_q),
      .pref_q      (pref_q),
      .to_done_err (to_done_err),
      .to_done_ok  (to_done_ok)
   );

   trip_decide u_decide (
      .id_b     (id_q),
      .cmp_b    (cmp_q),
      .pref_b   (pref_q),
      .dir_o    (dir_w),
      .status_o (status_w)
   );

   assign slot_act = (state == ST_RD_ID) || (state == ST_RD_CMP) || (state == ST_WR_DIR);

   trip_slot_if #(.REQ_STYLE(REQ_STYLE)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .slot_act (slot_act),
      .slot_ack (slot_ack_i),
      .slot_req (slot_req_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         err_q    <= 1'b0;
      end else if (to_done_err) begin
         status_q <= STAT_NOBODY;
         err_q    <= 1'b1;
      end else if (to_done_ok) begin
         status_q <= status_w;
         err_q    <= 1'b0;
      end
   end

   assign slot_wr_o   = (state == ST_WR_DIR);
   assign slot_wbit_o = slot_wr_o & dir_w;
   assign busy_o      = (state != ST_IDLE);
   assign done_o      = (state == ST_DONE);
   assign restart_o   = done_o & err_q;
   assign status_o    = status_q;
endmodule

// File: rtl/srch_triplet_chk.sv
module srch_triplet_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       start_i,
   input logic       busy_o,
   input logic       done_o,
   input logic       restart_o,
   input logic [2:0] status_o,
   input logic       slot_req_o,
   input logic       slot_wr_o,
   input logic       slot_wbit_o,
   input logic       slot_ack_i
);
   logic wbit_seen_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wbit_seen_q <= 1'b0;
      else if (slot_wr_o && slot_ack_i) wbit_seen_q <= slot_wbit_o;
   end

   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !busy_o |=> busy_o);                                         // R8
   AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !slot_req_o);                                               // R10
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);                                                    // R9
   AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(status_o));                                         // R9
   AST_ERR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && restart_o |-> status_o == 3'b011);                            // R2
   AST_ONE_SIDED: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && (status_o[0] != status_o[1]) |-> status_o[2] == status_o[0]); // R4
   AST_DIR_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !restart_o |-> status_o[2] == wbit_seen_q);                   // R6
endmodule

bind srch_triplet_unit srch_triplet_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .restart_o   (restart_o),
   .status_o    (status_o),
   .slot_req_o  (slot_req_o),
   .slot_wr_o   (slot_wr_o),
   .slot_wbit_o (slot_wbit_o),
   .slot_ack_i  (slot_ack_i)
);

// File: tb/srch_triplet_unit_tb.sv
module srch_triplet_unit_tb;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       pref_dir_i = 1'b0;
   logic       busy_o, done_o, restart_o;
   logic [2:0] status_o;
   logic       slot_req_o, slot_wr_o, slot_wbit_o;
   logic       slot_ack_i = 1'b0;
   logic       slot_rbit_i = 1'b0;
   int         checks = 0;
   int         errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   srch_triplet_unit u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .pref_dir_i(pref_dir_i),
      .busy_o(busy_o), .done_o(done_o), .restart_o(restart_o), .status_o(status_o),
      .slot_req_o(slot_req_o), .slot_wr_o(slot_wr_o), .slot_wbit_o(slot_wbit_o),
      .slot_ack_i(slot_ack_i), .slot_rbit_i(slot_rbit_i)
   );

   function automatic logic [2:0] exp_status(input logic id, input logic cmp, input logic pref);
      if (id && cmp) return 3'b011;
      if (id != cmp) return {id, cmp, id};
      return {pref, cmp, id};
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // serve one slot request at negedge granularity
   task automatic serve(input logic exp_wr, input logic exp_wbit, input logic rbit,
                        input int lat, input bit disturb, input string tag);
      int guard = 0;
      while (!slot_req_o && guard < 50) begin @(negedge clk); guard++; end
      chk({tag, " R1/R6 request seen"}, slot_req_o, 1'b1);
      chk({tag, " R1/R6 slot kind"}, slot_wr_o, exp_wr);
      if (exp_wr) chk({tag, " R6 write bit"}, slot_wbit_o, exp_wbit);
      for (int k = 0; k < lat; k++) begin
         if (disturb && k == 0) begin start_i = 1'b1; pref_dir_i = ~pref_dir_i; end
         else start_i = 1'b0;
         @(negedge clk);
         if (k == lat - 1) begin
            chk({tag, " R10 req held"}, slot_req_o, 1'b1);
            chk({tag, " R10 no early done"}, done_o, 1'b0);
         end
      end
      start_i = 1'b0;
      slot_ack_i = 1'b1; slot_rbit_i = rbit;
      @(negedge clk);
      slot_ack_i = 1'b0; slot_rbit_i = 1'b0;
   endtask

   task automatic run_op(input logic id, input logic cmp, input logic pref,
                         input int lat, input bit disturb);
      logic [2:0] e;
      e = exp_status(id, cmp, pref);
      @(negedge clk);
      start_i = 1'b1; pref_dir_i = pref;
      @(negedge clk);
      start_i = 1'b0; pref_dir_i = ~pref;   // R7: later change must not matter
      chk("R8 busy after start", busy_o, 1'b1);
      serve(1'b0, 1'b0, id,  lat, disturb, "R1 id read");
      serve(1'b0, 1'b0, cmp, lat, disturb, "R1 cmp read");
      if (!(id && cmp)) serve(1'b1, e[2], 1'b0, lat, 1'b0, "R6 dir write");
      chk("R9 done raised", done_o, 1'b1);
      chk((id && cmp) ? "R2 error code" : ((id != cmp) ? "R4/R5 status" : "R3/R7 status"),
          status_o, e);
      chk("R2/R5 restart flag", restart_o, (id && cmp));
      chk("R2/R6 no extra request", slot_req_o, 1'b0);
      @(negedge clk);
      chk("R9 done one cycle", done_o, 1'b0);
      chk("R9 status held", status_o, e);
      chk("R8 idle after done", busy_o, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      chk("R11 busy in reset", busy_o, 1'b0);
      chk("R11 req in reset", slot_req_o, 1'b0);
      chk("R11 status in reset", status_o, 3'b000);
      chk("R11 done in reset", {done_o, restart_o}, 2'b00);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 idle after reset", {busy_o, done_o, slot_req_o}, 3'b000);

      // directed corners
      run_op(1'b1, 1'b1, 1'b0, 0, 1'b0);   // R2 no response
      run_op(1'b1, 1'b1, 1'b1, 2, 1'b1);   // R2 with start disturbance
      run_op(1'b0, 1'b0, 1'b1, 0, 1'b0);   // R3 pref 1
      run_op(1'b0, 1'b0, 1'b0, 1, 1'b1);   // R3 pref 0, R8 start ignored
      run_op(1'b1, 1'b0, 1'b0, 0, 1'b0);   // R4 -> 3'b101
      run_op(1'b0, 1'b1, 1'b1, 0, 1'b0);   // R4 -> 3'b010
      run_op(1'b0, 1'b0, 1'b1, 20, 1'b0);  // R10 long wait

      // random mix
      for (int n = 0; n < 60; n++) begin
         logic id, cmp, pref;
         int lat;
         bit dis;
         id = 1'($urandom); cmp = 1'($urandom); pref = 1'($urandom);
         lat = int'($urandom % 5);
         dis = (lat > 0) && ($urandom % 3 == 0);
         run_op(id, cmp, pref, lat, dis);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule